// File: doc/BRIEF.md
# Converter Serial Frame Port

This block is the device side of the serial port on a multichannel 14-bit sampling converter. A host lowers chip select to open a frame, clocks SCLK and drives SDI. The block answers on a tri-state SDO, given here as a data pin and an output-enable pin. Opening a frame does three things. It samples the result of the channel chosen in the previous frame, it starts a conversion timer, and it starts collecting a 16-bit configuration word, most significant bit first. The timer runs from an oscillator tick divided down from the block clock, not from SCLK.

Sixteen SCLK falling edges carry the configuration word in. The sixteenth edge then hands the line over to the result: it presents the result MSB, and each later falling edge moves SDO on by one bit. After the 14 bits, SDO stays low until chip select rises and SDO goes to high impedance. The word is committed only when the frame got all 16 bits. If the conversion has not finished by the handover, a sticky error flag is raised and the frame's data is marked invalid.

SCLK, SDI and chip select are resynchronised into the block clock, so the block clock must run well above SCLK. The host's SCLK paces every bit on both phases. The device cannot stall the host, so there is no back-pressure, and a host that reads too early gets data flagged invalid instead.

Top module: `adc_serial_port`

## Requirements
- R1: After reset, sdo_oe is 0, cfg_word is 0 (so channel 0 is selected), conv_late_err is 0 and frame_invalid is 0.
- R2: From the chip-select falling edge until the 16th SCLK falling edge, sdo_oe is 1 and sdo is 0.
- R3: SDI is captured MSB first on the first 16 SCLK falling edges of a frame. When chip select rises after at least 16 falling edges, the captured word appears on cfg_word.
- R4: The channel converted in a frame is given by cfg_word bits [CH_W-1:0] as committed before that frame's chip-select falling edge. conv_chan shows that channel from the frame start.
- R5: At the 16th SCLK falling edge, sdo shows result bit 13. At falling edge 16+j it shows bit 13-j, so bit 0 is shown after edge 29 and read at edge 30.
- R6: From the 30th SCLK falling edge until chip select rises, sdo is 0.
- R7: SDI is ignored after the 16th falling edge; toggling it does not change the committed word.
- R8: When chip select rises, sdo_oe goes to 0 and stays 0 until the next frame.
- R9: A frame that ends with fewer than 16 SCLK falling edges leaves cfg_word unchanged.
- R10: If the conversion (CONV_TICKS oscillator ticks of OSC_DIV clocks each) has not finished at the 16th falling edge, conv_late_err is set and stays set until reset. frame_invalid is set for that frame and cleared at the next frame start.
- R11: The result is sampled at the chip-select falling edge; changes on chan_results later in the frame do not alter the bits sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the oscillator source |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select from host, active low |
| sclk | input | 1 | Serial clock from host, idles low |
| sdi | input | 1 | Serial data in, captured on SCLK falling edges |
| chan_results | input | NCH*14 | Converter result for each channel, channel c at bits [14c+13:14c] |
| sdo | output | 1 | Serial data out value |
| sdo_oe | output | 1 | Output enable for SDO; 0 means high impedance |
| cfg_word | output | 16 | Committed configuration word |
| conv_chan | output | CH_W | Channel converted in the current frame |
| conv_late_err | output | 1 | Sticky flag: a conversion was late at handover |
| frame_invalid | output | 1 | Data of the current or last frame is invalid |

## Verification
The bench builds the block with NCH=8, OSC_DIV=4 and CONV_TICKS=30, so a conversion takes 120 block clocks. At a 12-clock SCLK period the handover comes well after the conversion ends, so the result bits can be checked one by one. A 4-clock SCLK period reaches the handover before the timer ends, which exercises the late-conversion flag. The eight channels carry distinct result values, so a channel pipelined by one frame shows in the data. The result bus is also overwritten inside a frame to show that the sample is held.

// File: rtl/adc_sfi_pkg.sv
package adc_sfi_pkg;
  localparam int CFG_W     = 16;
  localparam int RES_W     = 14;
  localparam int TAIL_EDGE = CFG_W + RES_W;
  localparam int CNT_W     = $clog2(TAIL_EDGE + 1);
  localparam int SYNC_STAGES = 2;
  typedef enum logic [1:0] {
    IDX_CS   = 2'd0,
    IDX_SCLK = 2'd1,
    IDX_SDI  = 2'd2
  } pin_idx_e;
endpackage

// File: rtl/sfi_pin_sync.sv
module sfi_pin_sync
  import adc_sfi_pkg::*;
#(
  parameter int STAGES = SYNC_STAGES
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sclk,
  input  logic sdi,
  output logic cs_fall,
  output logic cs_rise,
  output logic sclk_fall,
  output logic sdi_s
);
  localparam logic [2:0] IDLE_LVL = 3'b001;

  logic [2:0] stg_q [STAGES];
  logic [2:0] prev_q;
  logic [2:0] cur;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= IDLE_LVL;
      prev_q <= IDLE_LVL;
    end else begin
      stg_q[0] <= {sdi, sclk, cs_n};
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
      prev_q <= stg_q[STAGES-1];
    end
  end

  assign cur       = stg_q[STAGES-1];
  assign cs_fall   = prev_q[IDX_CS] & ~cur[IDX_CS];
  assign cs_rise   = ~prev_q[IDX_CS] & cur[IDX_CS];
  assign sclk_fall = prev_q[IDX_SCLK] & ~cur[IDX_SCLK];
  assign sdi_s     = cur[IDX_SDI];
endmodule

// File: rtl/sfi_conv_timer.sv
module sfi_conv_timer #(
  parameter int OSC_DIV    = 4,
  parameter int CONV_TICKS = 30
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic done
);
  localparam int TCK_W = $clog2(CONV_TICKS + 1);

  logic             run_q;
  logic             osc_tick;
  logic [TCK_W-1:0] ticks_q;

  generate
    if (OSC_DIV <= 1) begin : g_nodiv
      assign osc_tick = run_q;
    end else begin : g_div
      localparam int DIV_W = $clog2(OSC_DIV);
      logic [DIV_W-1:0] div_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          div_q <= '0;
        else if (start)      div_q <= '0;
        else if (run_q)      div_q <= (div_q == DIV_W'(OSC_DIV - 1)) ? '0 : div_q + 1'b1;
      end
      assign osc_tick = run_q && (div_q == DIV_W'(OSC_DIV - 1));
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      ticks_q <= '0;
    end else if (start) begin
      run_q   <= 1'b1;
      ticks_q <= '0;
    end else if (osc_tick && !done) begin
      ticks_q <= ticks_q + 1'b1;
    end
  end

  assign done = run_q && (ticks_q == TCK_W'(CONV_TICKS));

  a_r10_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);
  a_r10_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !done);
endmodule

// File: rtl/sfi_frame_engine.sv
module sfi_frame_engine
  import adc_sfi_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             stop,
  input  logic             sclk_fall,
  input  logic             sdi,
  input  logic [RES_W-1:0] result,
  output logic [CFG_W-1:0] word_in,
  output logic             word_full,
  output logic             handover,
  output logic             sdo,
  output logic             sdo_oe
);
  logic             act_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CFG_W-1:0] in_sreg;
  logic [RES_W-1:0] out_sreg;
  logic             sdo_q, oe_q;
  logic             step;

  assign step     = act_q && sclk_fall;
  assign handover = step && (cnt_q == CNT_W'(CFG_W - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q    <= 1'b0;
      cnt_q    <= '0;
      in_sreg  <= '0;
      out_sreg <= '0;
      sdo_q    <= 1'b0;
      oe_q     <= 1'b0;
    end else if (start) begin
      act_q    <= 1'b1;
      cnt_q    <= '0;
      out_sreg <= '0;
      sdo_q    <= 1'b0;
      oe_q     <= 1'b1;
    end else if (stop) begin
      act_q <= 1'b0;
      sdo_q <= 1'b0;
      oe_q  <= 1'b0;
    end else if (step) begin
      if (cnt_q < CNT_W'(CFG_W)) in_sreg <= {in_sreg[CFG_W-2:0], sdi};
      if (cnt_q != CNT_W'(TAIL_EDGE)) cnt_q <= cnt_q + 1'b1;
      if (handover) begin
        sdo_q    <= result[RES_W-1];
        out_sreg <= {result[RES_W-2:0], 1'b0};
      end else if (cnt_q >= CNT_W'(CFG_W)) begin
        sdo_q    <= out_sreg[RES_W-1];
        out_sreg <= {out_sreg[RES_W-2:0], 1'b0};
      end
    end
  end

  assign word_in   = in_sreg;
  assign word_full = cnt_q >= CNT_W'(CFG_W);
  assign sdo       = sdo_q;
  assign sdo_oe    = oe_q;

  a_r2_low_before_handover: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_q && cnt_q < CNT_W'(CFG_W)) |-> !sdo_q);
  a_r6_tail_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && cnt_q == CNT_W'(TAIL_EDGE)) |-> !sdo_q);
  a_r7_sdi_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && cnt_q >= CNT_W'(CFG_W) && !start) |=> $stable(in_sreg));
  a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> !oe_q);
endmodule

// File: rtl/adc_serial_port.sv
module adc_serial_port
  import adc_sfi_pkg::*;
#(
  parameter int NCH        = 8,
  parameter int OSC_DIV    = 4,
  parameter int CONV_TICKS = 30,
  localparam int CH_W      = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cs_n,
  input  logic                 sclk,
  input  logic                 sdi,
  input  logic [NCH*RES_W-1:0] chan_results,
  output logic                 sdo,
  output logic                 sdo_oe,
  output logic [CFG_W-1:0]     cfg_word,
  output logic [CH_W-1:0]      conv_chan,
  output logic                 conv_late_err,
  output logic                 frame_invalid
);
  logic             cs_fall, cs_rise, sclk_fall, sdi_s;
  logic             conv_done;
  logic [CFG_W-1:0] word_in;
  logic             word_full, handover;
  logic [CFG_W-1:0] cfg_q;
  logic [CH_W-1:0]  next_ch, chan_q;
  logic [RES_W-1:0] picked, sample_q;
  logic             err_q, inval_q;

  sfi_pin_sync u_sync (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .cs_fall(cs_fall), .cs_rise(cs_rise), .sclk_fall(sclk_fall), .sdi_s(sdi_s)
  );

  sfi_conv_timer #(.OSC_DIV(OSC_DIV), .CONV_TICKS(CONV_TICKS)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(cs_fall), .done(conv_done)
  );

  sfi_frame_engine u_frame (
    .clk(clk), .rst_n(rst_n), .start(cs_fall), .stop(cs_rise),
    .sclk_fall(sclk_fall), .sdi(sdi_s), .result(sample_q),
    .word_in(word_in), .word_full(word_full), .handover(handover),
    .sdo(sdo), .sdo_oe(sdo_oe)
  );

  assign next_ch = (int'(cfg_q[CH_W-1:0]) < NCH) ? cfg_q[CH_W-1:0] : '0;
  assign picked  = chan_results[next_ch*RES_W +: RES_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q    <= '0;
      chan_q   <= '0;
      sample_q <= '0;
      err_q    <= 1'b0;
      inval_q  <= 1'b0;
    end else begin
      if (cs_fall) begin
        chan_q   <= next_ch;
        sample_q <= picked;
        inval_q  <= 1'b0;
      end
      if (cs_rise && word_full) cfg_q <= word_in;
      if (handover && !conv_done) begin
        err_q   <= 1'b1;
        inval_q <= 1'b1;
      end
    end
  end

  assign cfg_word      = cfg_q;
  assign conv_chan     = chan_q;
  assign conv_late_err = err_q;
  assign frame_invalid = inval_q;

  a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);
  a_r9_commit_full_only: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_q) |-> $past(cs_rise && word_full));
  a_r11_sample_held: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_fall |=> $stable(sample_q));
endmodule

// File: tb/adc_serial_port_tb.sv
module adc_serial_port_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 8;
  localparam int RW  = 14;
  localparam int SLOW = 6;
  localparam int FAST = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic [NCH*RW-1:0] chan_results;
  logic sdo, sdo_oe, conv_late_err, frame_invalid;
  logic [15:0] cfg_word;
  logic [2:0] conv_chan;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_serial_port #(.NCH(NCH), .OSC_DIV(4), .CONV_TICKS(30)) u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .chan_results(chan_results), .sdo(sdo), .sdo_oe(sdo_oe),
    .cfg_word(cfg_word), .conv_chan(conv_chan),
    .conv_late_err(conv_late_err), .frame_invalid(frame_invalid)
  );

  function automatic logic [RW-1:0] resv(int ch);
    return RW'(14'h1200 + ch * 14'h0137);
  endfunction

  task automatic load_bus();
    for (int c = 0; c < NCH; c++) chan_results[c*RW +: RW] = resv(c);
  endtask

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_frame(input logic [15:0] word, input int nfalls, input int half,
                           input bit swap, output logic [RW-1:0] got,
                           output bit pre_ok, output bit tail_ok);
    @(negedge clk) cs_n = 1'b0;
    repeat (6) @(negedge clk);
    pre_ok = (sdo_oe === 1'b1) && (sdo === 1'b0);
    got = '0;
    tail_ok = 1'b1;
    for (int k = 1; k <= nfalls; k++) begin
      sdi = (k <= 16) ? word[16-k] : k[0];
      sclk = 1'b1;
      repeat (half) @(negedge clk);
      sclk = 1'b0;
      repeat (half) @(negedge clk);
      if (swap && k == 1) chan_results = '1;
      if (k < 16) pre_ok &= (sdo_oe === 1'b1) && (sdo === 1'b0);
      else if (k <= 29) got[29-k] = sdo;
      else tail_ok &= (sdo === 1'b0);
    end
    @(negedge clk) cs_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic t_reset();
    check(sdo_oe === 1'b0, "R1 oe", 32'(sdo_oe), 0);
    check(cfg_word === 16'h0, "R1 cfg", 32'(cfg_word), 0);
    check(conv_late_err === 1'b0 && frame_invalid === 1'b0, "R1 flags",
          32'({conv_late_err, frame_invalid}), 0);
  endtask

  task automatic t_first_frame();
    logic [RW-1:0] got; bit pre_ok, tail_ok;
    run_frame(16'hA5C5, 33, SLOW, 1'b0, got, pre_ok, tail_ok);
    check(pre_ok, "R2 low before handover", 32'(pre_ok), 1);
    check(got === resv(0), "R5 result bits (R4 channel 0)", 32'(got), 32'(resv(0)));
    check(tail_ok, "R6 tail zero", 32'(tail_ok), 1);
    check(sdo_oe === 1'b0, "R8 hi-z after cs", 32'(sdo_oe), 0);
    check(cfg_word === 16'hA5C5, "R3 commit", 32'(cfg_word), 32'hA5C5);
    check(frame_invalid === 1'b0, "R10 no late", 32'(frame_invalid), 0);
  endtask

  task automatic t_pipeline();
    logic [RW-1:0] got; bit pre_ok, tail_ok;
    run_frame(16'h3C63, 30, SLOW, 1'b1, got, pre_ok, tail_ok);
    check(conv_chan === 3'd5, "R4 conv_chan", 32'(conv_chan), 5);
    check(got === resv(5), "R4 R11 pipelined held result", 32'(got), 32'(resv(5)));
    check(cfg_word === 16'h3C63, "R3 second commit", 32'(cfg_word), 32'h3C63);
    load_bus();
    run_frame(16'h0007, 30, SLOW, 1'b0, got, pre_ok, tail_ok);
    check(got === resv(3), "R4 channel 3", 32'(got), 32'(resv(3)));
  endtask

  task automatic t_ignore_sdi();
    logic [RW-1:0] got; bit pre_ok, tail_ok;
    run_frame(16'h5A0F, 40, SLOW, 1'b0, got, pre_ok, tail_ok);
    check(cfg_word === 16'h5A0F, "R7 sdi ignored after 16", 32'(cfg_word), 32'h5A0F);
    check(got === resv(7), "R5 channel 7 data", 32'(got), 32'(resv(7)));
  endtask

  task automatic t_short();
    logic [RW-1:0] got; bit pre_ok, tail_ok;
    run_frame(16'hFFF2, 10, SLOW, 1'b0, got, pre_ok, tail_ok);
    check(cfg_word === 16'h5A0F, "R9 short frame", 32'(cfg_word), 32'h5A0F);
    check(sdo_oe === 1'b0, "R8 hi-z short", 32'(sdo_oe), 0);
  endtask

  task automatic t_late();
    logic [RW-1:0] got; bit pre_ok, tail_ok;
    check(conv_late_err === 1'b0, "R10 clear before late", 32'(conv_late_err), 0);
    run_frame(16'h0001, 20, FAST, 1'b0, got, pre_ok, tail_ok);
    check(conv_late_err === 1'b1, "R10 late flag", 32'(conv_late_err), 1);
    check(frame_invalid === 1'b1, "R10 frame invalid", 32'(frame_invalid), 1);
    check(cfg_word === 16'h0001, "R3 commit fast", 32'(cfg_word), 1);
    run_frame(16'h0002, 30, SLOW, 1'b0, got, pre_ok, tail_ok);
    check(conv_late_err === 1'b1, "R10 sticky", 32'(conv_late_err), 1);
    check(frame_invalid === 1'b0, "R10 invalid cleared", 32'(frame_invalid), 0);
    check(got === resv(1), "R5 after late", 32'(got), 32'(resv(1)));
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    load_bus();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_first_frame();
    t_pipeline();
    t_ignore_sdi();
    t_short();
    t_late();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule